// File: doc/BRIEF.md
# Remote Program Character Interpreter

This block sits behind a bus listener and turns a stream of 7-bit ASCII program characters into the instrument's active settings. The settings are measurement range, function, sample/hold enable and trigger mode. A letter selects which setting the next character targets, and a digit after it supplies the value. While the instrument is under local control, the settings simply follow the front-panel inputs. Under remote control the panel is ignored and only bus programming changes them.

The character source presents a one-cycle `chr_valid` strobe with the character on `chr_data`. The block answers with a one-cycle `chr_done`, and the bus side uses that pulse to signal readiness for the next character. An end character closes the programming session. After it, every character is discarded until the bus side reports a fresh listen addressing through `relisten`. A malformed pair raises a sticky error flag.

Top module: `prog_interp`

## Requirements
- R1: While `rst` is high, range and function load from `fp_range`/`fp_func`, sample/hold and trigger mode read 0, and `prog_end` and `prog_err` read 0.
- R2: In local mode (registered `remote` low), all four settings follow the front-panel inputs, one clock after they are sampled.
- R3: In remote mode, changes on the front-panel inputs do not affect any setting.
- R4: In remote mode, 'R' (0x52) followed by a digit '0'..'7' (0x30..0x37) sets the range to that digit's value.
- R5: 'F' (0x46) followed by a digit no greater than parameter FUNC_MAX (default 5) sets the function. A larger digit leaves the function unchanged and sets `prog_err`.
- R6: 'H' (0x48) and 'T' (0x54) followed by '0' or '1' set sample/hold and trigger mode respectively. Any other digit leaves the setting unchanged and sets `prog_err`.
- R7: A non-digit character after a selector letter sets `prog_err`, leaves every setting unchanged and cancels the selection, so a later digit is discarded.
- R8: Range digits '8' and '9' are rejected. The range is unchanged and `prog_err` is set.
- R9: 'E' (0x45) sets `prog_end`. While it is set, all characters are discarded. A `relisten` pulse clears `prog_end` and `prog_err`.
- R10: `chr_done` is high in exactly the cycle after each `chr_valid` strobe, and low otherwise.
- R11: Characters received in local mode are discarded. They neither arm a selection nor end the session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| remote | input | 1 | Remote-control request from the bus side |
| relisten | input | 1 | One-cycle pulse: the device was addressed to listen again |
| chr_valid | input | 1 | One-cycle strobe: `chr_data` holds a character |
| chr_data | input | 7 | ASCII program character |
| chr_done | output | 1 | One-cycle pulse: the character has been processed |
| fp_range | input | 3 | Front-panel range setting |
| fp_func | input | 3 | Front-panel function setting |
| fp_sh | input | 1 | Front-panel sample/hold enable |
| fp_trig | input | 1 | Front-panel trigger mode |
| range_o | output | 3 | Active range |
| func_o | output | 3 | Active function |
| sh_o | output | 1 | Active sample/hold enable |
| trig_o | output | 1 | Active trigger mode |
| prog_end | output | 1 | Programming session closed by the end character |
| prog_err | output | 1 | Sticky error from a malformed or out-of-limit pair |

## Verification
Each selector is driven with digits at its limits: '0' and '7' for range, FUNC_MAX and FUNC_MAX+1 for function, and '1' and '2' for the flags. This separates accepted values from rejected ones. The pair selector–selector, followed by a digit, distinguishes a routing state that is cancelled from one that lingers. Letters sent in local mode, with remote mode entered before a digit, distinguish discarded characters from characters that arm silently. An end character followed by a valid pair, repeated after `relisten`, confirms both the lockout and its release.

// File: rtl/prog_pkg.sv
package prog_pkg;

    localparam int RANGE_W = 3;
    localparam int FUNC_W  = 3;
    localparam int VAL_W   = (RANGE_W > FUNC_W) ? RANGE_W : FUNC_W;
    localparam int DIG_W   = 4;
    localparam int CHR_W   = 7;

    localparam logic [CHR_W-1:0] CH_RANGE = 7'h52;
    localparam logic [CHR_W-1:0] CH_FUNC  = 7'h46;
    localparam logic [CHR_W-1:0] CH_SH    = 7'h48;
    localparam logic [CHR_W-1:0] CH_TRIG  = 7'h54;
    localparam logic [CHR_W-1:0] CH_END   = 7'h45;
    localparam logic [CHR_W-1:0] CH_ZERO  = 7'h30;
    localparam logic [CHR_W-1:0] CH_NINE  = 7'h39;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RANGE,
        SEL_FUNC,
        SEL_SH,
        SEL_TRIG
    } sel_e;

    typedef struct packed {
        logic             is_digit;
        logic [DIG_W-1:0] dval;
        sel_e             sel;
        logic             is_end;
    } chr_info_t;

    typedef struct packed {
        logic [RANGE_W-1:0] range;
        logic [FUNC_W-1:0]  func;
        logic               sh;
        logic               trig;
    } settings_t;

    function automatic sel_e letter_to_sel(input logic [CHR_W-1:0] c);
        case (c)
            CH_RANGE: return SEL_RANGE;
            CH_FUNC:  return SEL_FUNC;
            CH_SH:    return SEL_SH;
            CH_TRIG:  return SEL_TRIG;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/prog_char_decode.sv
module prog_char_decode
    import prog_pkg::*;
(
    input  logic [CHR_W-1:0] chr,
    output chr_info_t        info
);

    always_comb begin
        info.is_digit = (chr >= CH_ZERO) && (chr <= CH_NINE);
        info.dval     = chr[DIG_W-1:0];
        info.sel      = letter_to_sel(chr);
        info.is_end   = (chr == CH_END);
    end

endmodule

// File: rtl/prog_route_fsm.sv
module prog_route_fsm
    import prog_pkg::*;
#(
    parameter int RANGE_MAX = 7,
    parameter int FUNC_MAX  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rem_q,
    input  logic             relisten,
    input  logic             chr_valid,
    input  chr_info_t        info,
    output sel_e             wr_sel,
    output logic [VAL_W-1:0] wr_val,
    output logic             locked,
    output logic             err
);

    localparam logic [DIG_W-1:0] RMAX = DIG_W'(RANGE_MAX);
    localparam logic [DIG_W-1:0] FMAX = DIG_W'(FUNC_MAX);

    sel_e armed;
    logic accept;
    logic in_limit;

    assign accept = chr_valid && rem_q && !locked && !relisten;

    always_comb begin
        case (armed)
            SEL_RANGE: in_limit = info.dval <= RMAX;
            SEL_FUNC:  in_limit = info.dval <= FMAX;
            SEL_SH,
            SEL_TRIG:  in_limit = info.dval <= DIG_W'(1);
            default:   in_limit = 1'b0;
        endcase
    end

    always_comb begin
        wr_sel = SEL_NONE;
        wr_val = info.dval[VAL_W-1:0];
        if (accept && !info.is_end && armed != SEL_NONE && info.is_digit && in_limit)
            wr_sel = armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= SEL_NONE;
            locked <= 1'b0;
            err    <= 1'b0;
        end else if (relisten) begin
            armed  <= SEL_NONE;
            locked <= 1'b0;
            err    <= 1'b0;
        end else if (accept) begin
            if (info.is_end) begin
                locked <= 1'b1;
                armed  <= SEL_NONE;
            end else if (armed != SEL_NONE) begin
                armed <= SEL_NONE;
                if (!(info.is_digit && in_limit))
                    err <= 1'b1;
            end else begin
                armed <= info.sel;
            end
        end
    end

    // R9: lockout persists until re-addressing
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (rst)
        locked && !relisten |=> locked);

    // R7: error flag is sticky
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err && !relisten |=> err);

    // R7: any accepted character consumes an armed selection
    p_arm_consumed_r7: assert property (@(posedge clk) disable iff (rst)
        accept && armed != SEL_NONE |=> armed == SEL_NONE);

endmodule

// File: rtl/prog_setting_bank.sv
module prog_setting_bank
    import prog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rem_q,
    input  settings_t        fp,
    input  sel_e             wr_sel,
    input  logic [VAL_W-1:0] wr_val,
    output settings_t        q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q.range <= fp.range;
            q.func  <= fp.func;
            q.sh    <= 1'b0;
            q.trig  <= 1'b0;
        end else if (!rem_q) begin
            q <= fp;
        end else begin
            case (wr_sel)
                SEL_RANGE: q.range <= wr_val[RANGE_W-1:0];
                SEL_FUNC:  q.func  <= wr_val[FUNC_W-1:0];
                SEL_SH:    q.sh    <= wr_val[0];
                SEL_TRIG:  q.trig  <= wr_val[0];
                default:   ;
            endcase
        end
    end

    // R3: in remote mode the range moves only on a range write
    p_range_hold_r3: assert property (@(posedge clk) disable iff (rst)
        rem_q && wr_sel != SEL_RANGE |=> $stable(q.range));

    // R3: in remote mode the function moves only on a function write
    p_func_hold_r3: assert property (@(posedge clk) disable iff (rst)
        rem_q && wr_sel != SEL_FUNC |=> $stable(q.func));

endmodule

// File: rtl/prog_interp.sv
module prog_interp
    import prog_pkg::*;
#(
    parameter int RANGE_MAX = 7,
    parameter int FUNC_MAX  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       remote,
    input  logic       relisten,
    input  logic       chr_valid,
    input  logic [6:0] chr_data,
    output logic       chr_done,
    input  logic [2:0] fp_range,
    input  logic [2:0] fp_func,
    input  logic       fp_sh,
    input  logic       fp_trig,
    output logic [2:0] range_o,
    output logic [2:0] func_o,
    output logic       sh_o,
    output logic       trig_o,
    output logic       prog_end,
    output logic       prog_err
);

    logic             rem_q;
    chr_info_t        info;
    sel_e             wr_sel;
    logic [VAL_W-1:0] wr_val;
    settings_t        fp;
    settings_t        q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q    <= 1'b0;
            chr_done <= 1'b0;
        end else begin
            rem_q    <= remote;
            chr_done <= chr_valid;
        end
    end

    assign fp = '{range: fp_range, func: fp_func, sh: fp_sh, trig: fp_trig};

    prog_char_decode u_dec (
        .chr  (chr_data),
        .info (info)
    );

    prog_route_fsm #(
        .RANGE_MAX (RANGE_MAX),
        .FUNC_MAX  (FUNC_MAX)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rem_q     (rem_q),
        .relisten  (relisten),
        .chr_valid (chr_valid),
        .info      (info),
        .wr_sel    (wr_sel),
        .wr_val    (wr_val),
        .locked    (prog_end),
        .err       (prog_err)
    );

    prog_setting_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .rem_q  (rem_q),
        .fp     (fp),
        .wr_sel (wr_sel),
        .wr_val (wr_val),
        .q      (q)
    );

    assign range_o = q.range;
    assign func_o  = q.func;
    assign sh_o    = q.sh;
    assign trig_o  = q.trig;

    // R10: a strobe is answered in the next cycle
    p_done_follows_r10: assert property (@(posedge clk) disable iff (rst)
        chr_valid |=> chr_done);

    // R10: no answer without a strobe
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !chr_valid |=> !chr_done);

endmodule

// File: tb/prog_interp_bench.sv
module prog_interp_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       remote = 1'b0, relisten = 1'b0, chr_valid = 1'b0;
    logic [6:0] chr_data = '0;
    logic       chr_done;
    logic [2:0] fp_range = 3'd3, fp_func = 3'd2;
    logic       fp_sh = 1'b1, fp_trig = 1'b1;
    logic [2:0] range_o, func_o;
    logic       sh_o, trig_o, prog_end, prog_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    prog_interp u_prog_interp (
        .clk(clk), .rst(rst), .remote(remote), .relisten(relisten),
        .chr_valid(chr_valid), .chr_data(chr_data), .chr_done(chr_done),
        .fp_range(fp_range), .fp_func(fp_func), .fp_sh(fp_sh), .fp_trig(fp_trig),
        .range_o(range_o), .func_o(func_o), .sh_o(sh_o), .trig_o(trig_o),
        .prog_end(prog_end), .prog_err(prog_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one strobe; also checks R10 on every character
    task automatic send(input logic [6:0] c);
        @(negedge clk);
        chr_valid = 1'b1;
        chr_data  = c;
        @(negedge clk);
        chr_valid = 1'b0;
        chk("R10 done pulse", chr_done, 1);
        @(negedge clk);
        chk("R10 done single", chr_done, 0);
    endtask

    task automatic pulse_relisten();
        @(negedge clk);
        relisten = 1'b1;
        @(negedge clk);
        relisten = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 range", range_o, 3);
        chk("R1 func", func_o, 2);
        chk("R1 sh", sh_o, 0);
        chk("R1 trig", trig_o, 0);
        chk("R1 end", prog_end, 0);
        chk("R1 err", prog_err, 0);
        chk("R1 done", chr_done, 0);
    endtask

    task automatic t_local();
        rst = 1'b0;
        fp_range = 3'd5; fp_func = 3'd4; fp_sh = 1'b1; fp_trig = 1'b0;
        @(negedge clk);
        chk("R2 range", range_o, 5);
        chk("R2 func", func_o, 4);
        chk("R2 sh", sh_o, 1);
        chk("R2 trig", trig_o, 0);
        fp_range = 3'd1; fp_func = 3'd0; fp_sh = 1'b0; fp_trig = 1'b1;
        @(negedge clk);
        chk("R2 range", range_o, 1);
        chk("R2 func", func_o, 0);
        chk("R2 sh", sh_o, 0);
        chk("R2 trig", trig_o, 1);
    endtask

    task automatic t_local_chars();
        send(7'h52);
        send(7'h45);
        chk("R11 no end in local", prog_end, 0);
        remote = 1'b1;
        repeat (2) @(negedge clk);
        send(7'h36);
        chk("R11 no arm from local", range_o, 1);
        fp_range = 3'd7; fp_func = 3'd5; fp_sh = 1'b1; fp_trig = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 range held", range_o, 1);
        chk("R3 func held", func_o, 0);
        chk("R3 sh held", sh_o, 0);
        chk("R3 trig held", trig_o, 1);
    endtask

    task automatic t_range();
        send(7'h52); send(7'h35);
        chk("R4 range 5", range_o, 5);
        send(7'h52); send(7'h30);
        chk("R4 range 0", range_o, 0);
        send(7'h52); send(7'h37);
        chk("R4 range 7", range_o, 7);
        chk("R4 no err", prog_err, 0);
        send(7'h52); send(7'h38);
        chk("R8 range 8 rejected", range_o, 7);
        chk("R8 err", prog_err, 1);
        send(7'h52); send(7'h39);
        chk("R8 range 9 rejected", range_o, 7);
        pulse_relisten();
        chk("R9 relisten clears err", prog_err, 0);
    endtask

    task automatic t_func();
        send(7'h46); send(7'h33);
        chk("R5 func 3", func_o, 3);
        send(7'h46); send(7'h35);
        chk("R5 func max", func_o, 5);
        chk("R5 no err", prog_err, 0);
        send(7'h46); send(7'h36);
        chk("R5 func over max", func_o, 5);
        chk("R5 err", prog_err, 1);
        pulse_relisten();
    endtask

    task automatic t_flags();
        send(7'h48); send(7'h31);
        chk("R6 sh 1", sh_o, 1);
        send(7'h54); send(7'h30);
        chk("R6 trig 0", trig_o, 0);
        chk("R6 no err", prog_err, 0);
        send(7'h48); send(7'h32);
        chk("R6 sh bad digit", sh_o, 1);
        chk("R6 err", prog_err, 1);
        pulse_relisten();
    endtask

    task automatic t_bad_pair();
        send(7'h52); send(7'h46);
        chk("R7 err", prog_err, 1);
        chk("R7 range", range_o, 7);
        send(7'h32);
        chk("R7 arm cancelled range", range_o, 7);
        chk("R7 arm cancelled func", func_o, 5);
        pulse_relisten();
    endtask

    task automatic t_end();
        send(7'h45);
        chk("R9 end", prog_end, 1);
        send(7'h52); send(7'h31);
        chk("R9 locked", range_o, 7);
        chk("R9 locked err", prog_err, 0);
        pulse_relisten();
        chk("R9 end cleared", prog_end, 0);
        send(7'h52); send(7'h31);
        chk("R9 unlocked", range_o, 1);
    endtask

    initial begin
        t_reset();
        t_local();
        t_local_chars();
        t_range();
        t_func();
        t_flags();
        t_bad_pair();
        t_end();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule